// File: doc/BRIEF.md
# Comma Word Aligner for 8B/10B Line Streams

This block sits behind a deserializer that delivers 8B/10B line bits a few at a time. It watches every bit offset for the seven-bit comma prefix that only the K28.1, K28.5 and K28.7 special characters carry. It accepts that prefix in either running-disparity polarity and fixes the 10-bit character boundary once the prefix keeps turning up at one offset. After that it hands out framed 10-bit code groups with a strobe. It also flags symbols that carry a comma and flags the second half of the K28.5 + D16.2 idle pair.

A separate checker watches the raw bit stream for runs of equal bits longer than five, which a legal stream never contains. Alignment is held against stray comma-like patterns and is only given up after a number of misplaced commas in a row. Decoding to bytes, disparity checking of data and clock recovery belong to other blocks.

Top module: `comma_word_aligner`

## Requirements
- R1: After reset, `aligned`, `symValid`, `commaDet`, `idleDet` and `runErr` are low and the aligner is hunting.
- R2: `inData[IN_W-1]` is the earliest line bit of a word and `symOut[9]` is the earliest bit of a symbol. A comma is a symbol whose first seven bits are 0011111 or 1100000.
- R3: `aligned` rises in the cycle after the third comma (LOCK_N) found at the same bit offset modulo 10. Any of the 10 offsets can be chosen. A comma at a different offset before lock restarts the count at that offset.
- R4: While `aligned` is high at the start of a cycle, each 10-bit slot that ends on the boundary within that cycle's word gives one `symValid` pulse in the next cycle, with `symOut` holding that slot.
- R5: `commaDet` is high together with `symValid` exactly when the emitted symbol is a comma.
- R6: While aligned, a comma at another offset neither moves the boundary nor drops `aligned`, unless it is the fourth such comma in a row. A comma on the boundary clears the count of misplaced commas.
- R7: The fourth misplaced comma in a row (UNLOCK_N) drops `aligned` in the next cycle. The block then needs three new commas at one offset to lock again.
- R8: `idleDet` is high together with `symValid` when the emitted symbol is D16.2 (1001000101 or 0110110101) and the ten line bits just before it form K28.5 (0011111010 or 1100000101).
- R9: `runErr` is high in the cycle after any word in which a bit makes the run of equal line bits longer than five.
- R10: A cycle with `inValid` low consumes no bits, changes no state, and is followed by a cycle with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | `inData` holds new line bits |
| inData | input | IN_W | Line bits, MSB earliest |
| symValid | output | 1 | Framed symbol strobe |
| symOut | output | 10 | Framed 10-bit code group, bit 9 earliest |
| commaDet | output | 1 | Emitted symbol is a comma |
| idleDet | output | 1 | Emitted symbol completes an idle pair |
| aligned | output | 1 | Boundary is locked |
| runErr | output | 1 | Run of more than five equal bits seen |

## Verification
The assertions assume that a word never holds two comma prefixes. This holds for widths up to a few bits, because the prefix cannot overlap a shifted copy of itself within that distance. The bench drives two-bit words, which keeps it inside this limit. The assertions also assume `inData` is only meaningful under `inValid`. The bench drives zeros on gap cycles and checks that gaps leave the framing untouched. The stimulus uses framed idle pairs, data and special characters of both polarities, bit slips that move the true boundary, and an over-long run of zeros. A reference model, worked out per word from the requirements, predicts every output.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int SYM_W   = 10;
  localparam int PH_W    = 4;
  localparam int PRE_W   = 7;
  localparam int MAX_RUN = 5;

  localparam logic [PRE_W-1:0] PRE_NEG  = 7'b0011111;
  localparam logic [SYM_W-1:0] IDLE_K_N = 10'b0011111010;
  localparam logic [SYM_W-1:0] IDLE_D_A = 10'b1001000101;
  localparam logic [SYM_W-1:0] IDLE_D_B = 10'b0110110101;

  typedef logic [PH_W-1:0] phase_t;

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCKED} align_st_t;

  // datapath -> control: a comma prefix seen in this word and where it ended
  typedef struct packed {
    logic   valid;
    phase_t ph;
  } hit_t;

  // control -> datapath: emit strobe enable and the locked boundary phase
  typedef struct packed {
    logic   emitEn;
    phase_t bndPh;
  } ctrl_t;

  function automatic logic isComma(input logic [SYM_W-1:0] s);
    return (s[SYM_W-1 -: PRE_W] == PRE_NEG) || (s[SYM_W-1 -: PRE_W] == ~PRE_NEG);
  endfunction

  function automatic logic isIdleK(input logic [SYM_W-1:0] s);
    return (s == IDLE_K_N) || (s == ~IDLE_K_N);
  endfunction

  function automatic logic isIdleD(input logic [SYM_W-1:0] s);
    return (s == IDLE_D_A) || (s == IDLE_D_B);
  endfunction
endpackage

// File: rtl/cwa_datapath.sv
module cwa_datapath
  import cwa_pkg::*;
#(
  parameter int IN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  input  ctrl_t             ctrl,
  output hit_t              hit,
  output logic              symValid,
  output logic [SYM_W-1:0]  symOut,
  output logic              commaDet,
  output logic              idleDet,
  output logic              runErr
);
  localparam int HIST_W = 2 * SYM_W;
  localparam int CAT_W  = HIST_W + IN_W;
  localparam int RUN_W  = $clog2(MAX_RUN + 2);
  localparam logic [PH_W:0]    SYM_WP  = (PH_W+1)'(SYM_W);
  localparam logic [PH_W:0]    STEP    = (PH_W+1)'(IN_W);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_RUN);
  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(MAX_RUN + 1);

  logic [HIST_W-1:0] hist;
  phase_t            bitPh;
  logic [CAT_W-1:0]  cat;
  assign cat = {hist, inData};

  logic [SYM_W-1:0] slotCur  [IN_W];
  logic [SYM_W-1:0] slotPrev [IN_W];
  phase_t           slotPh   [IN_W];
  logic             slotComma[IN_W];

  // one candidate slot per bit of the word; index 0 is the newest bit
  for (genvar j = 0; j < IN_W; j++) begin : g_slot
    localparam logic [PH_W:0] OFS = (PH_W+1)'(IN_W - 1 - j);
    logic [PH_W:0] phSum;
    assign phSum        = {1'b0, bitPh} + OFS;
    assign slotPh[j]    = (phSum >= SYM_WP) ? phase_t'(phSum - SYM_WP) : phase_t'(phSum);
    assign slotCur[j]   = cat[j+SYM_W-1 : j];
    assign slotPrev[j]  = cat[j+HIST_W-1 : j+SYM_W];
    assign slotComma[j] = isComma(slotCur[j]);
  end

  // newest comma wins if a wide word ever held two
  always_comb begin
    hit = '0;
    for (int j = IN_W - 1; j >= 0; j--) begin
      if (inValid && slotComma[j]) begin
        hit.valid = 1'b1;
        hit.ph    = slotPh[j];
      end
    end
  end

  logic             emitHit;
  logic [SYM_W-1:0] emitSym;
  logic             emitComma;
  logic             emitIdle;
  always_comb begin
    emitHit   = 1'b0;
    emitSym   = '0;
    emitComma = 1'b0;
    emitIdle  = 1'b0;
    for (int j = 0; j < IN_W; j++) begin
      if (inValid && ctrl.emitEn && (slotPh[j] == ctrl.bndPh)) begin
        emitHit   = 1'b1;
        emitSym   = slotCur[j];
        emitComma = slotComma[j];
        emitIdle  = isIdleD(slotCur[j]) && isIdleK(slotPrev[j]);
      end
    end
  end

  logic [RUN_W-1:0] runLen, runLenN;
  logic             runVal, runValN, runViol;
  always_comb begin
    runLenN = runLen;
    runValN = runVal;
    runViol = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if ((runLenN != '0) && (inData[i] == runValN)) begin
        if (runLenN != RUN_CAP) runLenN = runLenN + 1'b1;
      end else begin
        runLenN = RUN_W'(1);
      end
      runValN = inData[i];
      if (runLenN > RUN_LIM) runViol = 1'b1;
    end
  end

  logic [PH_W:0] phNext;
  assign phNext = {1'b0, bitPh} + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      bitPh    <= '0;
      runLen   <= '0;
      runVal   <= 1'b0;
      symValid <= 1'b0;
      symOut   <= '0;
      commaDet <= 1'b0;
      idleDet  <= 1'b0;
      runErr   <= 1'b0;
    end else begin
      symValid <= emitHit;
      commaDet <= emitHit && emitComma;
      idleDet  <= emitHit && emitIdle;
      runErr   <= inValid && runViol;
      if (emitHit) symOut <= emitSym;
      if (inValid) begin
        hist   <= cat[HIST_W-1:0];
        bitPh  <= (phNext >= SYM_WP) ? phase_t'(phNext - SYM_WP) : phase_t'(phNext);
        runLen <= runLenN;
        runVal <= runValN;
      end
    end
  end

  // R4: a symbol leaves only when the control had the boundary locked
  a_r4_emit_needs_lock: assert property (@(posedge clk) disable iff (rst)
    symValid |-> $past(ctrl.emitEn));
  // R5: a comma strobe always rides on a symbol that opens with a comma prefix
  a_r5_comma_shape: assert property (@(posedge clk) disable iff (rst)
    commaDet |-> (symValid && ((symOut[9:3] == 7'b0011111) || (symOut[9:3] == 7'b1100000))));
  // R8: the idle strobe marks the data half of the pair, never a comma
  a_r8_idle_on_data: assert property (@(posedge clk) disable iff (rst)
    idleDet |-> (symValid && !commaDet));
  // R10: a gap cycle produces no strobes
  a_r10_gap_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) |-> (!symValid && !runErr && !commaDet));
endmodule

// File: rtl/cwa_control.sv
module cwa_control
  import cwa_pkg::*;
#(
  parameter int LOCK_N   = 3,
  parameter int UNLOCK_N = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  hit_t  hit,
  output ctrl_t ctrl,
  output logic  aligned
);
  localparam int CNT_MAX = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_N - 1);
  localparam logic [CNT_W-1:0] UNLOCK_LAST = CNT_W'(UNLOCK_N - 1);

  align_st_t        state, stateN;
  phase_t           bndPh, bndPhN;
  logic [CNT_W-1:0] goodCnt, goodCntN;
  logic [CNT_W-1:0] badCnt, badCntN;

  always_comb begin
    stateN   = state;
    bndPhN   = bndPh;
    goodCntN = goodCnt;
    badCntN  = badCnt;
    if (hit.valid) begin
      unique case (state)
        ST_HUNT: begin
          stateN   = ST_VERIFY;
          bndPhN   = hit.ph;
          goodCntN = CNT_W'(1);
        end
        ST_VERIFY: begin
          if (hit.ph == bndPh) begin
            if (goodCnt >= LOCK_LAST) begin
              stateN  = ST_LOCKED;
              badCntN = '0;
            end else begin
              goodCntN = goodCnt + 1'b1;
            end
          end else begin
            bndPhN   = hit.ph;
            goodCntN = CNT_W'(1);
          end
        end
        ST_LOCKED: begin
          if (hit.ph == bndPh) begin
            badCntN = '0;
          end else if (badCnt >= UNLOCK_LAST) begin
            stateN  = ST_HUNT;
            badCntN = '0;
          end else begin
            badCntN = badCnt + 1'b1;
          end
        end
        default: stateN = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      bndPh   <= '0;
      goodCnt <= '0;
      badCnt  <= '0;
    end else begin
      state   <= stateN;
      bndPh   <= bndPhN;
      goodCnt <= goodCntN;
      badCnt  <= badCntN;
    end
  end

  assign aligned     = (state == ST_LOCKED);
  assign ctrl.emitEn = aligned;
  assign ctrl.bndPh  = bndPh;

  // R3: lock is only ever gained on a comma
  a_r3_lock_on_comma: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(hit.valid));
  // R6: the boundary does not move while lock is held
  a_r6_boundary_held: assert property (@(posedge clk) disable iff (rst)
    (aligned && $past(aligned)) |-> (bndPh == $past(bndPh)));
  // R7: lock is only lost on a comma away from the boundary
  a_r7_drop_on_misplaced: assert property (@(posedge clk) disable iff (rst)
    $fell(aligned) |-> $past(hit.valid && (hit.ph != bndPh)));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import cwa_pkg::*;
#(
  parameter int IN_W     = 2,
  parameter int LOCK_N   = 3,
  parameter int UNLOCK_N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  output logic              symValid,
  output logic [SYM_W-1:0]  symOut,
  output logic              commaDet,
  output logic              idleDet,
  output logic              aligned,
  output logic              runErr
);
  hit_t  hit;
  ctrl_t ctrl;

  cwa_datapath #(.IN_W(IN_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .ctrl     (ctrl),
    .hit      (hit),
    .symValid (symValid),
    .symOut   (symOut),
    .commaDet (commaDet),
    .idleDet  (idleDet),
    .runErr   (runErr)
  );

  cwa_control #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) i_control (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .ctrl    (ctrl),
    .aligned (aligned)
  );
endmodule

// File: tb/test_comma_word_aligner.sv
module test_comma_word_aligner;
  localparam int IN_W = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic [IN_W-1:0] inData = '0;
  logic            symValid, commaDet, idleDet, aligned, runErr;
  logic [9:0]      symOut;

  always #10 clk = ~clk;

  comma_word_aligner #(.IN_W(IN_W)) i_comma_word_aligner (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .symValid(symValid), .symOut(symOut), .commaDet(commaDet),
    .idleDet(idleDet), .aligned(aligned), .runErr(runErr)
  );

  typedef struct packed {
    logic       v;
    logic [9:0] sym;
    logic       c;
    logic       i;
    logic       a;
    logic       r;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  bit   bq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic [7:0] tag = 8'd3;

  // reference model state, built from the requirements
  int         mSt = 0;   // 0 hunt, 1 verify, 2 locked
  int         mPh = 0;
  int         mGood = 0;
  int         mBad = 0;
  int         mCnt = 0;
  logic [19:0] mHist = '0;
  int         mRunLen = 0;
  logic       mRunVal = 1'b0;

  localparam logic [9:0] K28_5N = 10'b0011111010;
  localparam logic [9:0] K28_5P = 10'b1100000101;
  localparam logic [9:0] D16_2A = 10'b1001000101;
  localparam logic [9:0] D16_2B = 10'b0110110101;
  localparam logic [9:0] K28_1N = 10'b0011111001;
  localparam logic [9:0] K28_7N = 10'b0011111000;
  localparam logic [9:0] D7_0N  = 10'b1110001011;
  localparam logic [9:0] D7_0P  = 10'b0001110100;

  function automatic bit commaOf(input logic [9:0] s);
    return (s[9:3] == 7'b0011111) || (s[9:3] == 7'b1100000);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic driveWord(input logic v, input logic [IN_W-1:0] w);
    exp_t e;
    bit   hitF;
    int   hitPh;
    @(negedge clk);
    inValid = v;
    inData  = v ? w : '0;
    e = '0;
    e.tag = tag;
    hitF = 0;
    hitPh = 0;
    if (v) begin
      for (int k = IN_W - 1; k >= 0; k--) begin
        int ph;
        mHist = {mHist[18:0], w[k]};
        ph = mCnt;
        mCnt = (mCnt + 1) % 10;
        if (mRunLen != 0 && w[k] == mRunVal) mRunLen++;
        else mRunLen = 1;
        mRunVal = w[k];
        if (mRunLen > 5) e.r = 1'b1;                       // R9
        if (commaOf(mHist[9:0])) begin hitF = 1; hitPh = ph; end
        if (mSt == 2 && ph == mPh) begin                   // R4
          e.v   = 1'b1;
          e.sym = mHist[9:0];
          e.c   = commaOf(mHist[9:0]);                     // R5
          e.i   = (mHist[9:0] == D16_2A || mHist[9:0] == D16_2B) &&
                  (mHist[19:10] == K28_5N || mHist[19:10] == K28_5P); // R8
        end
      end
      if (hitF) begin
        if (mSt == 0) begin mSt = 1; mPh = hitPh; mGood = 1; end
        else if (mSt == 1) begin
          if (hitPh == mPh) begin
            mGood++;
            if (mGood >= 3) begin mSt = 2; mBad = 0; end   // R3
          end else begin mPh = hitPh; mGood = 1; end
        end else begin
          if (hitPh == mPh) mBad = 0;                      // R6
          else begin
            mBad++;
            if (mBad >= 4) begin mSt = 0; mBad = 0; end    // R7
          end
        end
      end
    end
    e.a = (mSt == 2);
    q.push_back(e);
  endtask

  task automatic pump();
    while (bq.size() >= IN_W) begin
      logic [IN_W-1:0] w;
      for (int k = IN_W - 1; k >= 0; k--) w[k] = bq.pop_front();
      driveWord(1'b1, w);
    end
  endtask

  // R2: bits go out earliest first, i.e. the MSB of the symbol first
  task automatic sendBits(input logic [9:0] s, input int n);
    for (int k = n - 1; k >= 0; k--) bq.push_back(s[k]);
    pump();
  endtask

  task automatic sendSym(input logic [9:0] s);
    sendBits(s, 10);
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) driveWord(1'b0, '0);
  endtask

  task automatic idlePairs(input int n);
    for (int k = 0; k < n; k++) begin
      sendSym(K28_5N);
      sendSym(D16_2A);
    end
  endtask

  // monitor: compares each cycle's outputs with the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        string at;
        e = q.pop_front();
        at = $sformatf("R%0d aligned", e.tag);
        check(symValid == e.v, "R4 symValid", symValid, e.v);
        if (e.v && symValid) check(symOut == e.sym, "R4/R2 symOut", symOut, e.sym);
        check(commaDet == e.c, "R5 commaDet", commaDet, e.c);
        check(idleDet == e.i, "R8 idleDet", idleDet, e.i);
        check(aligned == e.a, at, aligned, e.a);
        check(runErr == e.r, "R9 runErr", runErr, e.r);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    check(aligned == 1'b0, "R1 aligned", aligned, 0);
    check(symValid == 1'b0, "R1 symValid", symValid, 0);
    check(commaDet == 1'b0, "R1 commaDet", commaDet, 0);
    check(idleDet == 1'b0, "R1 idleDet", idleDet, 0);
    check(runErr == 1'b0, "R1 runErr", runErr, 0);
    @(negedge clk);
    rst = 1'b0;

    // R3: lock from an odd offset, with R10 gaps inside the hunt
    tag = 8'd3;
    sendBits(10'b101, 3);
    idlePairs(1);
    tag = 8'd10;
    gap(3);
    tag = 8'd3;
    idlePairs(3);
    tag = 8'd10;
    gap(2);

    // R5/R8: other specials, both polarities of the idle pair, data
    tag = 8'd5;
    sendSym(D7_0N);
    sendSym(K28_1N);
    sendSym(D7_0P);
    sendSym(K28_7N);
    sendSym(D16_2A);
    sendSym(K28_5P);
    sendSym(D16_2B);
    sendSym(K28_5N);
    sendSym(D7_0P);
    idlePairs(2);

    // R6: slip the line by three bits; three misplaced commas keep lock
    tag = 8'd6;
    sendBits(10'b010, 3);
    idlePairs(3);
    // R7: the fourth misplaced comma drops lock
    tag = 8'd7;
    idlePairs(1);
    // R3: relock at the new offset
    tag = 8'd3;
    idlePairs(4);

    // R9: an over-long run of zeros, then clean idles
    tag = 8'd9;
    sendBits(10'b0000000, 7);
    idlePairs(3);
    sendBits(10'b1, 1);
    gap(4);

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule